// File: doc/BRIEF.md
# Shadow-Copy Store/Recall Sequencer

This controller governs a memory in which every volatile word has a nonvolatile twin. It decides when the volatile contents are saved into the shadow copy (a store) and when the shadow copy is loaded back (a recall). It drives a small array model through a phase command, and it holds the rest of the memory off the bus while a transfer runs. All durations are parameters counted in clock cycles.

A store can be asked for in four ways. A pulse marks the supply dropping below its switch level. An active-low request pin can be pulled down. A sequence detector upstream can send a software store pulse or a software recall pulse. A pulse marks the supply coming good again, and it starts the recall that was latched when the supply fell. Reset stands for power-on. A dirty flag records whether any write has been accepted since the last transfer finished, and stores started by the pin or by power loss are skipped when that flag is clear.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: During and after reset, busy_n_o is 1, inhibit_o is 0 and arr_cmd_o is 0 (none). The supply counts as low and a power-up recall is pending, so write requests are refused until pwr_good_i is pulsed.
- R2: A pwr_good_i pulse while the supply is low starts a recall. arr_cmd_o shows 3 (clear volatile) for PUP_RECALL_CYC/2 cycles, then 4 (load volatile) for the remaining cycles. inhibit_o is 1 and busy_n_o stays 1 throughout.
- R3: A software recall pulse runs code 3 for RECALL_CYC/2 cycles, then code 4 for the rest. It never issues 1 (erase shadow) or 2 (program shadow), so the shadow copy is left unchanged.
- R4: wr_accept_o follows wr_req_i only in the idle state, with the supply good and the pin high. An accepted write sets the dirty flag.
- R5: A store shows code 1 for STORE_CYC/2 cycles, then code 2 for the remaining cycles. busy_n_o is 0 and inhibit_o is 1 for the whole store, and both are released when it ends.
- R6: A software store runs whether or not the dirty flag is set.
- R7: When the pin falls, GRACE_CYC cycles pass with inhibit_o at 0 and writes refused. After that, a store runs if the dirty flag is set, and otherwise no store runs.
- R8: At the end of a pin grace window or of any store, if the pin is low, inhibit_o stays 1 with code 0 until the pin goes high. It drops one cycle after that.
- R9: On a pwr_loss_i pulse, a store runs if the dirty flag is set. Otherwise busy_n_o goes low for BLIP_CYC cycles while inhibit_o stays 0 and no command is issued.
- R10: Completing any store or recall clears the dirty flag, so a later pin store is skipped.
- R11: When requests arrive in the same cycle, power loss wins over the pin, the pin wins over software store, and software store wins over software recall.
- R12: Software pulses are ignored unless the sequencer is idle with the supply good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| pwr_loss_i | input | 1 | Pulse: supply fell below switch level |
| pwr_good_i | input | 1 | Pulse: supply back above switch level |
| store_req_n_i | input | 1 | Active-low external store request pin |
| sw_store_i | input | 1 | Pulse from sequence detector: store |
| sw_recall_i | input | 1 | Pulse from sequence detector: recall |
| wr_req_i | input | 1 | A write access is requested this cycle |
| wr_accept_o | output | 1 | The write is allowed into the array |
| busy_n_o | output | 1 | Open-drain-style busy, low during a store or a power-loss blip |
| inhibit_o | output | 1 | Global access inhibit |
| arr_cmd_o | output | 3 | Array phase: 0 none, 1 erase shadow, 2 program shadow, 3 clear volatile, 4 load volatile |

## Verification
The hardest case to reach is several requests landing in one cycle while the dirty flag is set and the pin is held low through the store. Only that case shows whether the power-loss path beats the grace window and whether the hold state follows. The bench first makes one accepted write. On a single falling clock edge it then raises power loss, the pin, and both software pulses together. It then tells the paths apart by the command in the first cycle (erase at once, not a silent grace window) and by how many cycles are spent holding. A second collision, with the pin and a software store only, confirms that the grace window comes before the erase.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_NV_ERASE  = 3'd1,
        CMD_NV_PROG   = 3'd2,
        CMD_VOL_CLEAR = 3'd3,
        CMD_VOL_LOAD  = 3'd4
    } arr_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GRACE,
        S_ST_ERASE,
        S_ST_PROG,
        S_RC_CLEAR,
        S_RC_LOAD,
        S_BLIP,
        S_HOLD
    } seq_state_e;

endpackage

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          expire_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // last cycle of a phase that was loaded with N lasts exactly N cycles
    assign expire_o = (cnt_q == CW'(1));

endmodule

// File: rtl/nvs_req.sv
module nvs_req (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_loss_i,
    input  logic pwr_good_i,
    input  logic pl_take_i,
    input  logic rc_take_i,
    output logic low_o,
    output logic pl_req_o,
    output logic rc_req_o
);

    typedef struct packed {
        logic supply_low;
        logic rc_pend;
        logic pl_pend;
    } req_t;

    req_t d, q;

    always_comb begin
        d = q;
        if (pwr_good_i) d.supply_low = 1'b0;
        if (pwr_loss_i) begin
            d.supply_low = 1'b1;
            d.rc_pend    = 1'b1;
            d.pl_pend    = 1'b1;
        end
        if (pl_take_i) d.pl_pend = 1'b0;
        if (rc_take_i) d.rc_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{supply_low: 1'b1, rc_pend: 1'b1, pl_pend: 1'b0};
        else        q <= d;
    end

    // a loss pulse acts in its own cycle so it outranks same-cycle requests
    assign low_o    = q.supply_low | pwr_loss_i;
    assign pl_req_o = q.pl_pend | pwr_loss_i;
    assign rc_req_o = q.rc_pend & ~low_o;

endmodule

// File: rtl/nv_shadow_ctrl.sv
module nv_shadow_ctrl #(
    parameter int STORE_CYC      = 10000,
    parameter int RECALL_CYC     = 20,
    parameter int PUP_RECALL_CYC = 550,
    parameter int GRACE_CYC      = 1,
    parameter int BLIP_CYC       = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_loss_i,
    input  logic       pwr_good_i,
    input  logic       store_req_n_i,
    input  logic       sw_store_i,
    input  logic       sw_recall_i,
    input  logic       wr_req_i,
    output logic       wr_accept_o,
    output logic       busy_n_o,
    output logic       inhibit_o,
    output logic [2:0] arr_cmd_o
);

    import nvs_pkg::*;

    localparam int ERASE_N  = STORE_CYC / 2;
    localparam int PROG_N   = STORE_CYC - ERASE_N;
    localparam int RC_CLR_N = RECALL_CYC / 2;
    localparam int RC_LD_N  = RECALL_CYC - RC_CLR_N;
    localparam int PU_CLR_N = PUP_RECALL_CYC / 2;
    localparam int PU_LD_N  = PUP_RECALL_CYC - PU_CLR_N;
    localparam int MAX_A    = (STORE_CYC > PUP_RECALL_CYC) ? STORE_CYC : PUP_RECALL_CYC;
    localparam int MAX_B    = (RECALL_CYC > GRACE_CYC) ? RECALL_CYC : GRACE_CYC;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ALL  = (MAX_C > BLIP_CYC) ? MAX_C : BLIP_CYC;
    localparam int CW       = $clog2(MAX_ALL + 1);

    typedef struct packed {
        seq_state_e state;
        logic       pup;
        logic       dirty;
    } seq_t;

    seq_t          d, q;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          expire;
    logic          low, pl_req, rc_req, pl_take, rc_take;
    logic          wr_ok;
    arr_cmd_e      cmd;

    nvs_req i_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_loss_i (pwr_loss_i),
        .pwr_good_i (pwr_good_i),
        .pl_take_i  (pl_take),
        .rc_take_i  (rc_take),
        .low_o      (low),
        .pl_req_o   (pl_req),
        .rc_req_o   (rc_req)
    );

    nvs_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ld),
        .val_i    (ld_val),
        .expire_o (expire)
    );

    assign wr_ok = wr_req_i && (q.state == S_IDLE) && store_req_n_i && !low;

    always_comb begin
        d       = q;
        ld      = 1'b0;
        ld_val  = '0;
        pl_take = 1'b0;
        rc_take = 1'b0;
        if (wr_ok) d.dirty = 1'b1;
        case (q.state)
            S_IDLE: begin
                if (pl_req) begin
                    pl_take = 1'b1;
                    ld      = 1'b1;
                    if (q.dirty) begin
                        d.state = S_ST_ERASE;
                        ld_val  = CW'(ERASE_N);
                    end else begin
                        d.state = S_BLIP;
                        ld_val  = CW'(BLIP_CYC);
                    end
                end else if (rc_req) begin
                    rc_take = 1'b1;
                    d.state = S_RC_CLEAR;
                    d.pup   = 1'b1;
                    ld      = 1'b1;
                    ld_val  = CW'(PU_CLR_N);
                end else if (!low) begin
                    if (!store_req_n_i) begin
                        d.state = S_GRACE;
                        ld      = 1'b1;
                        ld_val  = CW'(GRACE_CYC);
                    end else if (sw_store_i) begin
                        d.state = S_ST_ERASE;
                        ld      = 1'b1;
                        ld_val  = CW'(ERASE_N);
                    end else if (sw_recall_i) begin
                        d.state = S_RC_CLEAR;
                        d.pup   = 1'b0;
                        ld      = 1'b1;
                        ld_val  = CW'(RC_CLR_N);
                    end
                end
            end
            S_GRACE: begin
                if (expire) begin
                    if (q.dirty) begin
                        d.state = S_ST_ERASE;
                        ld      = 1'b1;
                        ld_val  = CW'(ERASE_N);
                    end else begin
                        d.state = S_HOLD;
                    end
                end
            end
            S_ST_ERASE: begin
                if (expire) begin
                    d.state = S_ST_PROG;
                    ld      = 1'b1;
                    ld_val  = CW'(PROG_N);
                end
            end
            S_ST_PROG: begin
                if (expire) begin
                    d.dirty = 1'b0;
                    d.state = store_req_n_i ? S_IDLE : S_HOLD;
                end
            end
            S_RC_CLEAR: begin
                if (expire) begin
                    d.state = S_RC_LOAD;
                    ld      = 1'b1;
                    ld_val  = q.pup ? CW'(PU_LD_N) : CW'(RC_LD_N);
                end
            end
            S_RC_LOAD: begin
                if (expire) begin
                    d.dirty = 1'b0;
                    d.state = S_IDLE;
                end
            end
            S_BLIP: begin
                if (expire) d.state = S_IDLE;
            end
            S_HOLD: begin
                if (store_req_n_i) d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_IDLE, pup: 1'b0, dirty: 1'b0};
        else        q <= d;
    end

    always_comb begin
        cmd       = CMD_NONE;
        busy_n_o  = 1'b1;
        inhibit_o = 1'b0;
        case (q.state)
            S_ST_ERASE: begin cmd = CMD_NV_ERASE;  busy_n_o = 1'b0; inhibit_o = 1'b1; end
            S_ST_PROG:  begin cmd = CMD_NV_PROG;   busy_n_o = 1'b0; inhibit_o = 1'b1; end
            S_RC_CLEAR: begin cmd = CMD_VOL_CLEAR; inhibit_o = 1'b1; end
            S_RC_LOAD:  begin cmd = CMD_VOL_LOAD;  inhibit_o = 1'b1; end
            S_BLIP:     busy_n_o  = 1'b0;
            S_HOLD:     inhibit_o = 1'b1;
            default:    cmd = CMD_NONE;
        endcase
    end

    assign arr_cmd_o   = cmd;
    assign wr_accept_o = wr_ok;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       store_req_n_i,
    input logic       wr_accept_o,
    input logic       busy_n_o,
    input logic       inhibit_o,
    input logic [2:0] arr_cmd_o
);

    // R5: programming is entered only straight from erasing
    p_prog_after_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd_o == 3'd2 && $past(arr_cmd_o) != 3'd2) |-> $past(arr_cmd_o) == 3'd1);

    // R2: loading is entered only straight from clearing
    p_load_after_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_cmd_o == 3'd4 && $past(arr_cmd_o) != 3'd4) |-> $past(arr_cmd_o) == 3'd3);

    // R4: no write gets through while access is inhibited
    p_no_wr_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o |-> !wr_accept_o);

    // R7: no write gets through while the pin is low
    p_no_wr_pin_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !store_req_n_i |-> !wr_accept_o);

    // R8: holding with the pin high releases on the next cycle
    p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_o && arr_cmd_o == 3'd0 && store_req_n_i) |=> !inhibit_o);

    // R9: a busy pulse without inhibit carries no array command
    p_blip_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n_o && !inhibit_o) |-> arr_cmd_o == 3'd0);

endmodule

bind nv_shadow_ctrl nvs_checker i_nvs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .store_req_n_i (store_req_n_i),
    .wr_accept_o   (wr_accept_o),
    .busy_n_o      (busy_n_o),
    .inhibit_o     (inhibit_o),
    .arr_cmd_o     (arr_cmd_o)
);

// File: tb/test_nv_shadow_ctrl.sv
module test_nv_shadow_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ST_C   = 10;
    localparam int RC_C   = 6;
    localparam int PU_C   = 8;
    localparam int GR_C   = 3;
    localparam int BL_C   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_loss = 1'b0, pwr_good = 1'b0, pin_n = 1'b1;
    logic       sw_store = 1'b0, sw_recall = 1'b0, wr_req = 1'b0;
    logic       wr_accept, busy_n, inhibit;
    logic [2:0] arr_cmd;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int c_er, c_pr, c_cl, c_ld, c_busy, c_inh, c_hold;
    logic [2:0] first_cmd;

    always #(CLK_PERIOD/2) clk = ~clk;

    nv_shadow_ctrl #(
        .STORE_CYC(ST_C), .RECALL_CYC(RC_C), .PUP_RECALL_CYC(PU_C),
        .GRACE_CYC(GR_C), .BLIP_CYC(BL_C)
    ) i_nv_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_loss_i(pwr_loss), .pwr_good_i(pwr_good),
        .store_req_n_i(pin_n), .sw_store_i(sw_store), .sw_recall_i(sw_recall),
        .wr_req_i(wr_req), .wr_accept_o(wr_accept), .busy_n_o(busy_n),
        .inhibit_o(inhibit), .arr_cmd_o(arr_cmd)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic observe(int n);
        c_er = 0; c_pr = 0; c_cl = 0; c_ld = 0; c_busy = 0; c_inh = 0; c_hold = 0;
        first_cmd = arr_cmd;
        for (int i = 0; i < n; i++) begin
            if (arr_cmd == 3'd1) c_er++;
            if (arr_cmd == 3'd2) c_pr++;
            if (arr_cmd == 3'd3) c_cl++;
            if (arr_cmd == 3'd4) c_ld++;
            if (!busy_n) c_busy++;
            if (inhibit) c_inh++;
            if (inhibit && arr_cmd == 3'd0) c_hold++;
            @(negedge clk);
        end
    endtask

    task automatic do_write(int exp_acc, string tag);
        @(negedge clk);
        wr_req = 1'b1;
        #1;
        check(tag, int'(wr_accept), exp_acc);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic idle_check(string tag);
        check({tag, " inhibit"}, int'(inhibit), 0);
        check({tag, " cmd"}, int'(arr_cmd), 0);
        check({tag, " busy_n"}, int'(busy_n), 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        wr_req = 1'b1;
        #1;
        idle_check("R1 in reset");
        check("R1 write refused in reset", int'(wr_accept), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        idle_check("R1 after reset");
        check("R1 write refused before power good", int'(wr_accept), 0);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic t_powerup;
        pwr_good = 1'b1;
        @(negedge clk);
        pwr_good = 1'b0;
        observe(14);
        check("R2 power-up clear cycles", c_cl, PU_C / 2);
        check("R2 power-up load cycles", c_ld, PU_C - PU_C / 2);
        check("R2 inhibit during recall", c_inh, PU_C);
        check("R2 busy stays high", c_busy, 0);
        idle_check("R2 idle after recall");
    endtask

    task automatic t_pin_clean;
        pin_n = 1'b0;
        wr_req = 1'b1;
        #1;
        check("R7 write refused with pin low", int'(wr_accept), 0);
        @(negedge clk);
        wr_req = 1'b0;
        observe(6);
        check("R10 no store after recall cleared dirty", c_er, 0);
        check("R7 grace without inhibit then hold", c_inh, 6 - GR_C);
        check("R8 hold cycles", c_hold, 6 - GR_C);
        check("R7 no busy", c_busy, 0);
        pin_n = 1'b1;
        @(negedge clk);
        check("R8 released after pin high", int'(inhibit), 0);
    endtask

    task automatic t_pin_dirty;
        do_write(1, "R4 write accepted in idle");
        pin_n = 1'b0;
        @(negedge clk);
        observe(20);
        check("R7 grace first", int'(first_cmd), 0);
        check("R5 erase cycles", c_er, ST_C / 2);
        check("R5 program cycles", c_pr, ST_C - ST_C / 2);
        check("R5 busy during store", c_busy, ST_C);
        check("R8 hold after store", c_hold, 20 - GR_C - ST_C);
        pin_n = 1'b1;
        @(negedge clk);
        idle_check("R8 idle after pin release");
    endtask

    task automatic t_sw_store;
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        observe(14);
        check("R6 clean software store erase", c_er, ST_C / 2);
        check("R6 clean software store program", c_pr, ST_C - ST_C / 2);
        check("R5 busy released", c_busy, ST_C);
        check("R5 no hold with pin high", c_hold, 0);
        do_write(1, "R4 write accepted");
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        observe(14);
        pin_n = 1'b0;
        @(negedge clk);
        observe(8);
        check("R10 pin store skipped after store", c_er, 0);
        pin_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sw_recall;
        sw_recall = 1'b1;
        @(negedge clk);
        sw_recall = 1'b0;
        observe(10);
        check("R3 clear cycles", c_cl, RC_C / 2);
        check("R3 load cycles", c_ld, RC_C - RC_C / 2);
        check("R3 shadow untouched", c_er + c_pr, 0);
        sw_recall = 1'b1;
        @(negedge clk);
        sw_recall = 1'b0;
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        observe(12);
        check("R12 store ignored during recall", c_er, 0);
    endtask

    task automatic t_power_loss;
        do_write(1, "R4 write before loss");
        pwr_loss = 1'b1;
        @(negedge clk);
        pwr_loss = 1'b0;
        observe(14);
        check("R9 loss store erase", c_er, ST_C / 2);
        check("R9 loss store busy", c_busy, ST_C);
        do_write(0, "R4 write refused with supply low");
        sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        observe(12);
        check("R12 software store ignored with supply low", c_er, 0);
        pwr_loss = 1'b1;
        @(negedge clk);
        pwr_loss = 1'b0;
        observe(6);
        check("R9 clean loss busy blip", c_busy, BL_C);
        check("R9 clean loss no command", c_er + c_pr, 0);
        check("R9 clean loss no inhibit", c_inh, 0);
        t_powerup();
    endtask

    task automatic t_priority;
        do_write(1, "R4 write before collision");
        pwr_loss = 1'b1; pin_n = 1'b0; sw_store = 1'b1; sw_recall = 1'b1;
        @(negedge clk);
        pwr_loss = 1'b0; sw_store = 1'b0; sw_recall = 1'b0;
        observe(14);
        check("R11 power loss wins: erase at once", int'(first_cmd), 1);
        check("R11 single store", c_er, ST_C / 2);
        check("R8 hold after loss store", c_hold, 14 - ST_C);
        pin_n = 1'b1;
        @(negedge clk);
        t_powerup();
        do_write(1, "R4 write before pin collision");
        pin_n = 1'b0; sw_store = 1'b1;
        @(negedge clk);
        sw_store = 1'b0;
        observe(16);
        check("R11 pin beats software: grace first", int'(first_cmd), 0);
        check("R11 pin store erase once", c_er, ST_C / 2);
        pin_n = 1'b1;
        @(negedge clk);
        sw_store = 1'b1; sw_recall = 1'b1;
        @(negedge clk);
        sw_store = 1'b0; sw_recall = 1'b0;
        observe(14);
        check("R11 store beats recall", c_er, ST_C / 2);
        check("R11 recall dropped", c_cl, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_powerup();
        t_pin_clean();
        t_pin_dirty();
        t_sw_store();
        t_sw_recall();
        t_power_loss();
        t_priority();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule